// File: doc/BRIEF.md
# Physical Memory Attribute Checker

This block screens every load, store and instruction-fetch request against two small tables of physical address regions. The first table lists regions that must bypass the cache: a request whose byte span fits completely inside one valid entry of that table is flagged uncacheable. The second table lists regions that tolerate unaligned accesses; an unaligned load or store is excused only when its span lies completely inside one valid entry of this second table, and otherwise a misaligned-address fault is raised with a load or store cause code.

A request is presented either at the virtual stage (before translation) or at the physical stage (after it). While any misaligned-tolerant region is enabled, the virtual-stage check always passes so that the decision is taken once the physical address is known. Both tables are loaded through one write port that selects a table and an entry. The decision logic is combinational; results appear on registered outputs one clock after the request strobe.

Top module: `pma_check`

## Requirements
- R1: After reset all response outputs are 0 and every entry of both tables is invalid.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high; while `rsp_valid` is low, `rsp_fault`, `rsp_error`, `rsp_uncacheable`, `rsp_cause` and `rsp_fault_addr` are all 0.
- R3: The required alignment is 2 to the power `req_align` bytes; an address is aligned when it is an exact multiple of that; an aligned read or write never faults.
- R4: A request with `req_mode` = 2 (instruction fetch) never faults and never raises `rsp_error`, at either stage.
- R5: At the virtual stage (`req_phys` = 0) with no valid misaligned-tolerant entry, an unaligned `req_vaddr` on a read or write faults, and `rsp_fault_addr` is `req_vaddr`.
- R6: At the virtual stage, while at least one misaligned-tolerant entry is valid, no request faults.
- R7: At the physical stage (`req_phys` = 1) an unaligned `req_paddr` is excused when `base <= req_paddr` and `req_paddr + req_size <= limit` for one valid misaligned-tolerant entry (limit exclusive); otherwise a read or write faults.
- R8: Mode encoding is 0 read, 1 write, 2 fetch, 3 reserved; a faulting read gives `rsp_cause` = 4 and a faulting write gives `rsp_cause` = 6.
- R9: At the physical stage the fault address is `req_vaddr` when `req_vaddr_ok` is 1 and `req_alt_addr` otherwise; with no fault or error `rsp_fault_addr` is 0.
- R10: A reserved-mode (3) request that fails the alignment rules raises `rsp_error` with the selected address, while `rsp_fault` and `rsp_cause` stay 0.
- R11: At the physical stage `rsp_uncacheable` is 1 exactly when `base <= req_paddr` and `req_paddr + req_size <= limit` for one valid uncacheable entry; at the virtual stage it is 0.
- R12: A write with `cfg_we` = 1 loads entry `cfg_idx` of table `cfg_sel` (0 uncacheable, 1 misaligned-tolerant) with base, limit and valid, used by requests from the next cycle; an entry written invalid never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region table write enable |
| cfg_sel | input | 1 | Table select: 0 uncacheable, 1 misaligned-tolerant |
| cfg_idx | input | $clog2(ENTRIES) | Entry index |
| cfg_base | input | ADDR_W | Region base (inclusive) |
| cfg_limit | input | ADDR_W | Region limit (exclusive) |
| cfg_valid | input | 1 | Entry enable |
| req_valid | input | 1 | Request strobe |
| req_phys | input | 1 | 0 virtual stage, 1 physical stage |
| req_mode | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| req_vaddr | input | ADDR_W | Virtual address |
| req_vaddr_ok | input | 1 | Virtual address is present |
| req_paddr | input | ADDR_W | Physical address |
| req_size | input | SIZE_W | Access size in bytes |
| req_align | input | ALIGN_W | Alignment exponent |
| req_alt_addr | input | ADDR_W | Fallback fault address |
| rsp_valid | output | 1 | Response strobe |
| rsp_uncacheable | output | 1 | Access is uncacheable |
| rsp_fault | output | 1 | Misaligned-address fault |
| rsp_cause | output | 4 | Fault cause code |
| rsp_fault_addr | output | ADDR_W | Faulting address |
| rsp_error | output | 1 | Reserved-mode request reached fault generation |

## Verification
The embedded assertions watch, every cycle, the response strobe timing and the quiet outputs while it is low, that fetches never fault, that fault and error never coexist, that cause codes are only 4 or 6, that the virtual stage stays silent while tolerant regions exist, and that table entries change only on writes. Whether a given address, size and alignment is judged correctly against region edges, which fault address is chosen and when uncacheable is flagged can only be shown by the bench's sweeps, which step addresses byte by byte across every region boundary for all modes, stages and alignments and compare each response with an arithmetic model.

// File: rtl/pma_check_pkg.sv
package pma_check_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_mode_e;

   typedef enum logic {
      TBL_UNCACHE  = 1'b0,
      TBL_MISALIGN = 1'b1
   } tbl_sel_e;

   localparam int CAUSE_W = 4;
   localparam logic [CAUSE_W-1:0] CAUSE_LOAD_MISALIGN  = 4'd4;
   localparam logic [CAUSE_W-1:0] CAUSE_STORE_MISALIGN = 4'd6;
   localparam int NUM_TABLES = 2;

endpackage

// File: rtl/pma_region_table.sv
module pma_region_table #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [$clog2(ENTRIES)-1:0]        wr_idx,
   input  logic [ADDR_W-1:0]                 wr_base,
   input  logic [ADDR_W-1:0]                 wr_limit,
   input  logic                              wr_valid,
   output logic [ENTRIES-1:0][ADDR_W-1:0]    base_o,
   output logic [ENTRIES-1:0][ADDR_W-1:0]    limit_o,
   output logic [ENTRIES-1:0]                valid_o
);

   localparam int IDX_W = $clog2(ENTRIES);

   initial begin
      assert (ENTRIES >= 2 && ENTRIES <= 64)
         else $error("pma_region_table: ENTRIES out of range");
      assert (ADDR_W >= 8)
         else $error("pma_region_table: ADDR_W too small");
   end

   logic [ENTRIES-1:0][ADDR_W-1:0] base_q;
   logic [ENTRIES-1:0][ADDR_W-1:0] limit_q;
   logic [ENTRIES-1:0]             valid_q;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic hit_w;
      assign hit_w = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[e]  <= '0;
            limit_q[e] <= '0;
            valid_q[e] <= 1'b0;
         end else if (hit_w) begin
            base_q[e]  <= wr_base;
            limit_q[e] <= wr_limit;
            valid_q[e] <= wr_valid;
         end
      end
   end

   assign base_o  = base_q;
   assign limit_o = limit_q;
   assign valid_o = valid_q;

   // R12
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(valid_q) && $stable(base_q) && $stable(limit_q));

   // R12
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(wr_idx)] == $past(wr_valid));

endmodule

// File: rtl/pma_span_match.sv
module pma_span_match #(
   parameter int ADDR_W  = 32,
   parameter int SIZE_W  = 4,
   parameter int ENTRIES = 4
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic [SIZE_W-1:0]              size,
   input  logic [ENTRIES-1:0][ADDR_W-1:0] base,
   input  logic [ENTRIES-1:0][ADDR_W-1:0] limit,
   input  logic [ENTRIES-1:0]             valid,
   output logic                           hit
);

   localparam int EXT_W = ADDR_W + 1;

   initial begin
      assert (SIZE_W >= 1 && SIZE_W < ADDR_W)
         else $error("pma_span_match: SIZE_W out of range");
   end

   logic [EXT_W-1:0]   span_lo;
   logic [EXT_W-1:0]   span_hi;
   logic [ENTRIES-1:0] fits;

   assign span_lo = {1'b0, addr};
   assign span_hi = span_lo + {{(EXT_W-SIZE_W){1'b0}}, size};

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      logic lo_ok;
      logic hi_ok;
      assign lo_ok   = {1'b0, base[e]} <= span_lo;
      assign hi_ok   = span_hi <= {1'b0, limit[e]};
      assign fits[e] = valid[e] && lo_ok && hi_ok;
   end

   assign hit = |fits;

endmodule

// File: rtl/pma_align_check.sv
module pma_align_check #(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_W    = 2,
   parameter bit MASK_SHIFT = 1'b1
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [ALIGN_W-1:0] align_exp,
   output logic               aligned
);

   initial begin
      assert (ALIGN_W >= 1 && (2 ** ALIGN_W) - 1 <= ADDR_W)
         else $error("pma_align_check: ALIGN_W too wide for ADDR_W");
   end

   logic [ADDR_W-1:0] low_mask;

   if (MASK_SHIFT) begin : g_shift
      assign low_mask = ~({ADDR_W{1'b1}} << align_exp);
   end else begin : g_thermo
      for (genvar k = 0; k < ADDR_W; k++) begin : g_bit
         assign low_mask[k] = (k < int'(align_exp));
      end
   end

   assign aligned = (addr & low_mask) == '0;

endmodule

// File: rtl/pma_check.sv
module pma_check
   import pma_check_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 4,
   parameter int ALIGN_W    = 2,
   parameter int ENTRIES    = 4,
   parameter bit MASK_SHIFT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic                       cfg_sel,
   input  logic [$clog2(ENTRIES)-1:0] cfg_idx,
   input  logic [ADDR_W-1:0]          cfg_base,
   input  logic [ADDR_W-1:0]          cfg_limit,
   input  logic                       cfg_valid,
   input  logic                       req_valid,
   input  logic                       req_phys,
   input  logic [1:0]                 req_mode,
   input  logic [ADDR_W-1:0]          req_vaddr,
   input  logic                       req_vaddr_ok,
   input  logic [ADDR_W-1:0]          req_paddr,
   input  logic [SIZE_W-1:0]          req_size,
   input  logic [ALIGN_W-1:0]         req_align,
   input  logic [ADDR_W-1:0]          req_alt_addr,
   output logic                       rsp_valid,
   output logic                       rsp_uncacheable,
   output logic                       rsp_fault,
   output logic [3:0]                 rsp_cause,
   output logic [ADDR_W-1:0]          rsp_fault_addr,
   output logic                       rsp_error
);

   initial begin
      assert (CAUSE_W == 4) else $error("pma_check: cause width mismatch");
      assert (ENTRIES >= 2) else $error("pma_check: need two or more entries");
   end

   // ---------------- region tables ----------------
   logic [NUM_TABLES-1:0][ENTRIES-1:0][ADDR_W-1:0] tbl_base;
   logic [NUM_TABLES-1:0][ENTRIES-1:0][ADDR_W-1:0] tbl_limit;
   logic [NUM_TABLES-1:0][ENTRIES-1:0]             tbl_valid;
   logic [NUM_TABLES-1:0]                          tbl_hit;

   for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
      logic sel_w;
      assign sel_w = cfg_we && (cfg_sel == 1'(t));

      pma_region_table #(
         .ADDR_W  (ADDR_W),
         .ENTRIES (ENTRIES)
      ) u_table (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (sel_w),
         .wr_idx   (cfg_idx),
         .wr_base  (cfg_base),
         .wr_limit (cfg_limit),
         .wr_valid (cfg_valid),
         .base_o   (tbl_base[t]),
         .limit_o  (tbl_limit[t]),
         .valid_o  (tbl_valid[t])
      );

      pma_span_match #(
         .ADDR_W  (ADDR_W),
         .SIZE_W  (SIZE_W),
         .ENTRIES (ENTRIES)
      ) u_match (
         .addr  (req_paddr),
         .size  (req_size),
         .base  (tbl_base[t]),
         .limit (tbl_limit[t]),
         .valid (tbl_valid[t]),
         .hit   (tbl_hit[t])
      );
   end

   logic unc_hit;
   logic tol_hit;
   logic tol_any;

   assign unc_hit = tbl_hit[TBL_UNCACHE];
   assign tol_hit = tbl_hit[TBL_MISALIGN];
   assign tol_any = |tbl_valid[TBL_MISALIGN];

   // ---------------- alignment ----------------
   logic va_aligned;
   logic pa_aligned;

   pma_align_check #(
      .ADDR_W     (ADDR_W),
      .ALIGN_W    (ALIGN_W),
      .MASK_SHIFT (MASK_SHIFT)
   ) u_align_va (
      .addr      (req_vaddr),
      .align_exp (req_align),
      .aligned   (va_aligned)
   );

   pma_align_check #(
      .ADDR_W     (ADDR_W),
      .ALIGN_W    (ALIGN_W),
      .MASK_SHIFT (MASK_SHIFT)
   ) u_align_pa (
      .addr      (req_paddr),
      .align_exp (req_align),
      .aligned   (pa_aligned)
   );

   // ---------------- decision ----------------
   acc_mode_e         mode;
   logic              is_fetch;
   logic              misfit;
   logic [ADDR_W-1:0] blame_addr;
   logic              nxt_fault;
   logic              nxt_error;
   logic [CAUSE_W-1:0] nxt_cause;
   logic [ADDR_W-1:0] nxt_addr;
   logic              nxt_unc;

   assign mode     = acc_mode_e'(req_mode);
   assign is_fetch = (mode == ACC_FETCH);

   always_comb begin
      if (!req_phys) begin
         misfit     = !tol_any && !is_fetch && !va_aligned;
         blame_addr = req_vaddr;
      end else begin
         misfit     = !is_fetch && !pa_aligned && !tol_hit;
         blame_addr = req_vaddr_ok ? req_vaddr : req_alt_addr;
      end
   end

   always_comb begin
      nxt_fault = 1'b0;
      nxt_error = 1'b0;
      nxt_cause = '0;
      if (misfit) begin
         unique case (mode)
            ACC_READ: begin
               nxt_fault = 1'b1;
               nxt_cause = CAUSE_LOAD_MISALIGN;
            end
            ACC_WRITE: begin
               nxt_fault = 1'b1;
               nxt_cause = CAUSE_STORE_MISALIGN;
            end
            default: nxt_error = 1'b1;
         endcase
      end
   end

   assign nxt_addr = misfit ? blame_addr : '0;
   assign nxt_unc  = req_phys && unc_hit;

   // ---------------- response registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid       <= 1'b0;
         rsp_uncacheable <= 1'b0;
         rsp_fault       <= 1'b0;
         rsp_cause       <= '0;
         rsp_fault_addr  <= '0;
         rsp_error       <= 1'b0;
      end else begin
         rsp_valid       <= req_valid;
         rsp_uncacheable <= req_valid && nxt_unc;
         rsp_fault       <= req_valid && nxt_fault;
         rsp_cause       <= req_valid ? nxt_cause : '0;
         rsp_fault_addr  <= req_valid ? nxt_addr : '0;
         rsp_error       <= req_valid && nxt_error;
      end
   end

   // ---------------- assertions ----------------
   // R2
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_fault && !rsp_error && !rsp_uncacheable
                     && rsp_cause == '0 && rsp_fault_addr == '0);

   // R4
   fetch_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_mode == 2'd2 |=> !rsp_fault && !rsp_error);

   // R8
   cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_cause == 4'd4 || rsp_cause == 4'd6));

   // R10
   fault_error_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_fault && rsp_error));

   // R10
   error_no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> rsp_cause == '0);

   // R6
   virt_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_phys && tol_any |=> !rsp_fault && !rsp_error);

   // R11
   virt_cacheable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_phys |=> !rsp_uncacheable);

endmodule

// File: tb/pma_check_test.sv
`timescale 1ns/1ps
module pma_check_test;

   localparam int AW = 32;
   localparam int SW = 4;
   localparam int LW = 2;
   localparam int NE = 4;
   localparam int IW = $clog2(NE);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [AW-1:0] cfg_base = '0;
   logic [AW-1:0] cfg_limit = '0;
   logic          cfg_valid = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_phys = 1'b0;
   logic [1:0]    req_mode = '0;
   logic [AW-1:0] req_vaddr = '0;
   logic          req_vaddr_ok = 1'b0;
   logic [AW-1:0] req_paddr = '0;
   logic [SW-1:0] req_size = '0;
   logic [LW-1:0] req_align = '0;
   logic [AW-1:0] req_alt_addr = '0;
   logic          rsp_valid;
   logic          rsp_uncacheable;
   logic          rsp_fault;
   logic [3:0]    rsp_cause;
   logic [AW-1:0] rsp_fault_addr;
   logic          rsp_error;

   always #4 clk = ~clk;

   pma_check #(.ADDR_W(AW), .SIZE_W(SW), .ALIGN_W(LW), .ENTRIES(NE)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
      .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
      .req_valid(req_valid), .req_phys(req_phys), .req_mode(req_mode),
      .req_vaddr(req_vaddr), .req_vaddr_ok(req_vaddr_ok), .req_paddr(req_paddr),
      .req_size(req_size), .req_align(req_align), .req_alt_addr(req_alt_addr),
      .rsp_valid(rsp_valid), .rsp_uncacheable(rsp_uncacheable),
      .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
      .rsp_fault_addr(rsp_fault_addr), .rsp_error(rsp_error)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // bench-side copy of the programmed regions: [table][entry]
   longint m_base  [2][NE];
   longint m_limit [2][NE];
   bit     m_valid [2][NE];

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic write_region(input int sel, input int idx, input longint b,
                               input longint l, input bit v);
      cfg_we    = 1'b1;
      cfg_sel   = sel[0];
      cfg_idx   = IW'(idx);
      cfg_base  = AW'(b);
      cfg_limit = AW'(l);
      cfg_valid = v;
      @(negedge clk);
      cfg_we = 1'b0;
      m_base[sel][idx]  = b;
      m_limit[sel][idx] = l;
      m_valid[sel][idx] = v;
   endtask

   function automatic bit inside_tbl(input int sel, input longint a, input longint s);
      for (int e = 0; e < NE; e++)
         if (m_valid[sel][e] && m_base[sel][e] <= a && a + s <= m_limit[sel][e])
            return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit any_tol();
      for (int e = 0; e < NE; e++) if (m_valid[1][e]) return 1'b1;
      return 1'b0;
   endfunction

   // one request; expected values come from the requirement text
   task automatic run_req(input bit phys, input int mode, input longint va,
                          input bit va_ok, input longint pa, input int align,
                          input int size, input longint alt);
      longint abytes, who, e_addr;
      bit     misfit, e_fault, e_err, e_unc;
      int     e_cause;
      req_valid = 1'b1; req_phys = phys; req_mode = 2'(mode);
      req_vaddr = AW'(va); req_vaddr_ok = va_ok; req_paddr = AW'(pa);
      req_align = LW'(align); req_size = SW'(size); req_alt_addr = AW'(alt);
      abytes = longint'(1) << align;
      if (!phys) begin
         misfit = !any_tol() && mode != 2 && (va % abytes) != 0;
         who    = va;
      end else begin
         misfit = mode != 2 && (pa % abytes) != 0 && !inside_tbl(1, pa, size);
         who    = va_ok ? va : alt;
      end
      e_fault = misfit && (mode == 0 || mode == 1);
      e_err   = misfit && mode == 3;
      e_cause = !e_fault ? 0 : (mode == 0 ? 4 : 6);
      e_addr  = misfit ? who : 0;
      e_unc   = phys && inside_tbl(0, pa, size);
      @(negedge clk);
      req_valid = 1'b0;
      check(phys ? "R7/R4/R3 fault" : "R5/R6/R4/R3 fault", rsp_fault, e_fault);
      check("R8 cause", rsp_cause, e_cause);
      check("R9/R5 fault_addr", rsp_fault_addr, e_addr);
      check("R10 error", rsp_error, e_err);
      check("R11 uncacheable", rsp_uncacheable, e_unc);
      check("R2 rsp_valid", rsp_valid, 1);
   endtask

   task automatic sweep_edges(input longint lo, input longint hi);
      for (longint a = lo; a < hi; a++)
         for (int al = 0; al < 4; al++)
            for (int md = 0; md < 4; md++)
               for (int ph = 0; ph < 2; ph++)
                  run_req(ph[0], md, a + 'h3001 * al, a[0], a, al, 1 << al,
                          'hA000_0000 | a);
   endtask

   initial begin
      for (int t = 0; t < 2; t++)
         for (int e = 0; e < NE; e++) begin
            m_base[t][e] = 0; m_limit[t][e] = 0; m_valid[t][e] = 0;
         end
      repeat (3) @(negedge clk);
      // R1: reset holds outputs at zero
      check("R1 valid", rsp_valid, 0);
      check("R1 fault", rsp_fault, 0);
      check("R1 uncacheable", rsp_uncacheable, 0);
      check("R1 error", rsp_error, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after release", rsp_valid, 0);

      // R1/R5/R8/R9/R10: empty tables, full sweep of low addresses
      for (int a = 0; a < 16; a++)
         for (int al = 0; al < 4; al++)
            for (int md = 0; md < 4; md++)
               for (int ph = 0; ph < 2; ph++)
                  for (int vo = 0; vo < 2; vo++)
                     run_req(ph[0], md, 'h5000 + a, vo[0], 'h40 + (a ^ 5), al,
                             1 << al, 'h7700 + a);

      // R2: quiet cycle after a request
      @(negedge clk);
      check("R2 idle valid", rsp_valid, 0);
      check("R2 idle fault", rsp_fault, 0);
      check("R2 idle addr", rsp_fault_addr, 0);

      // R12: program regions, including one entry written invalid
      write_region(1, 2, 'h100, 'h120, 1'b1);
      write_region(1, 0, 'h300, 'h340, 1'b0);
      write_region(0, 1, 'h200, 'h240, 1'b1);
      write_region(0, 3, 'h100, 'h110, 1'b0);

      // R7/R11/R12/R6: walk across every region edge
      sweep_edges('h0F8, 'h128);
      sweep_edges('h1F8, 'h248);
      sweep_edges('h2F8, 'h308);
      sweep_edges('h338, 'h344);

      // R12/R6: disable the tolerant entry, virtual stage checks return
      write_region(1, 2, 'h100, 'h120, 1'b0);
      for (int a = 0; a < 16; a++)
         for (int md = 0; md < 4; md++)
            run_req(1'b0, md, 'h101 + a, 1'b1, 'h101 + a, 2, 4, 'h9);

      // R12: uncacheable entry disabled, reprogrammed elsewhere
      write_region(0, 1, 'h600, 'h610, 1'b1);
      sweep_edges('h5FC, 'h614);

      finished = 1'b1;
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

endmodule